// File: doc/BRIEF.md
# Looping Audio Stream Accelerator

This block lets a DSP core pull audio samples out of an external byte-wide memory. Software sets up the run through a small register file: a 32-bit current pointer, a loop-start pointer and a loop-end pointer (each held as a high and a low 16-bit half), a format code, two history registers, a predictor/scale byte and a table of sixteen predictor coefficient pairs. After that, each pulse on a data port fetches the next sample, advances the pointer and writes the new pointer back into the current-pointer halves.

The format code chooses how bytes become a sample. It can be big-endian 16-bit PCM, which also updates the history pair; an unsigned byte, which is read through the alternate port; or 4-bit ADPCM. The ADPCM nibble is decoded by a separate step unit that uses the coefficient table and the history pair. When a read pushes the pointer to or past the loop end, the pointer jumps back to the loop start, so a sound can be replayed without help from software. The alternate port can also write a 16-bit word out to memory. Codes that the block does not know raise a sticky error flag.

Top module: `stream_accel`

## Requirements
- R1: After reset, every register reads as zero, `busy`, `done`, `err` and `mem_valid` are low and `sample` is zero. Register indices: 0 format, 1/2 current high/low, 3/4 loop-start high/low, 5/6 loop-end high/low, 7 predictor/scale byte, 8 history-1, 9 history-2, 10 status (bit 0 = error), 32+2k and 33+2k coefficient 1 and 2 of pair k. Each 32-bit pointer is the high half shifted up 16 bits, ORed with the low half.
- R2: A main-port read in format 0x000A fetches the byte at the pointer as the upper byte and the byte at pointer+1 as the lower byte, and advances the pointer by 2.
- R3: A main-port read in format 0x000A or 0x0000 moves history-1 into history-2 and loads history-1 with the new sample. No other access changes the history pair.
- R4: An alternate-port read in format 0x0005 returns one byte zero-extended and advances the pointer by 1. In format 0x000A it returns a 16-bit big-endian word, advances by 2 and leaves the history pair unchanged.
- R5: After any read, if the advanced pointer is greater than or equal to the loop end (unsigned 32-bit compare), it is replaced by the loop start.
- R6: The pointer that results from each access is written back into the current high and low registers, where software can read it.
- R7: An alternate-port write in format 0x000A stores bits 15:8 of `wr_data` at the pointer and bits 7:0 at pointer+1, then advances the pointer by 2 with no loop-end check.
- R8: A read whose format is not supported on its port falls back to a 16-bit big-endian fetch with an advance of 2 and sets the error flag. A write in any format other than 0x000A touches no memory, leaves the pointer as it is and sets the error flag. The flag is sticky and is cleared by writing 1 to bit 0 of the status register.
- R9: In format 0x0000 (main port) the pointer counts nibbles. When its low 4 bits are zero, the byte at (pointer with the low 4 bits cleared)/2 is loaded into the predictor/scale register first and the pointer advances by 2. The nibble then comes from byte pointer/2, taking the high nibble when the pointer is even. The nibble is a signed value n. With pair k = bits 7:4 and s = bits 3:0 of predictor/scale, the sample is n·2^s + floor((1024 + c1·hist1 + c2·hist2)/2048), clamped to ±32767. The pointer then advances by 1.
- R10: When `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold in the next cycle. Any number of stall cycles gives the same result.
- R11: `busy` rises in the cycle after a request and falls after the single-cycle `done` pulse. Requests that arrive while busy are dropped. When several requests coincide, main read wins over alternate read, which wins over alternate write.
- R12: Register writes are dropped while busy. A register write made in the same cycle as a request takes effect before that access uses the registers.
- R13: `sample` is registered. It changes only when a read completes and holds through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register index for read and write |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from cfg_addr) |
| rd_main | input | 1 | Main data port read request |
| rd_alt | input | 1 | Alternate data port read request |
| wr_alt | input | 1 | Alternate data port write request |
| wr_data | input | 16 | Word for alternate-port write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the commit cycle |
| sample | output | 16 | Last sample read |
| err | output | 1 | Sticky unsupported-format flag |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts request; read byte valid in the same cycle |
| mem_rdata | input | 8 | Memory read byte |

## Verification
Software configuration and the streaming engine both write the pointer registers, and they can act in the same cycle in two ways. In the first, the bench raises a main-port read together with a write to the current-pointer low half and expects the sample and the written-back pointer to come from the newly written address. In the second, it stretches an access with memory stalls and, while the access is in flight, issues both a pointer write and a second request. It then expects the pointer to show only the engine's advance and `done` to pulse once. The loop reload and the write-back are checked on the same commit edge, with the advanced pointer placed just below, exactly on and beyond the loop end.

// File: rtl/stream_accel_pkg.sv
package stream_accel_pkg;
  parameter int unsigned REG_W      = 16;
  parameter int unsigned ADDR_W     = 2 * REG_W;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned HDR_SEL_W  = 4;
  localparam int unsigned COEF_PAIRS = 1 << HDR_SEL_W;
  localparam int unsigned COEF_N     = 2 * COEF_PAIRS;
  localparam int unsigned CIDX_W     = $clog2(COEF_N);
  localparam int unsigned CFG_AW     = CIDX_W + 1;

  // register indices below the coefficient window
  localparam logic [CFG_AW-1:0] IX_FMT   = 6'd0;
  localparam logic [CFG_AW-1:0] IX_CURH  = 6'd1;
  localparam logic [CFG_AW-1:0] IX_CURL  = 6'd2;
  localparam logic [CFG_AW-1:0] IX_BEGH  = 6'd3;
  localparam logic [CFG_AW-1:0] IX_BEGL  = 6'd4;
  localparam logic [CFG_AW-1:0] IX_LIMH  = 6'd5;
  localparam logic [CFG_AW-1:0] IX_LIML  = 6'd6;
  localparam logic [CFG_AW-1:0] IX_PSC   = 6'd7;
  localparam logic [CFG_AW-1:0] IX_HIST1 = 6'd8;
  localparam logic [CFG_AW-1:0] IX_HIST2 = 6'd9;
  localparam logic [CFG_AW-1:0] IX_STAT  = 6'd10;

  localparam logic [REG_W-1:0] FMT_NIB  = 16'h0000;
  localparam logic [REG_W-1:0] FMT_BYTE = 16'h0005;
  localparam logic [REG_W-1:0] FMT_W16  = 16'h000A;

  typedef enum logic [1:0] {OP_MAIN, OP_ALTRD, OP_ALTWR} op_e;

  typedef enum logic [2:0] {
    MD_NIB,     // ADPCM, history shift
    MD_PCM,     // 16-bit with history shift
    MD_BYTE,    // unsigned byte
    MD_PLAIN,   // 16-bit, no history
    MD_RAW,     // unsupported read, 16-bit fallback + error
    MD_WR,      // 16-bit write
    MD_WRBAD    // unsupported write: error only
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_HDR, S_B0, S_B1, S_WR0, S_WR1, S_FIN
  } st_e;

  function automatic mode_e pick_mode(input op_e op, input logic [REG_W-1:0] f);
    mode_e m;
    unique case (op)
      OP_MAIN:  m = (f == FMT_NIB) ? MD_NIB  : (f == FMT_W16) ? MD_PCM   : MD_RAW;
      OP_ALTRD: m = (f == FMT_BYTE) ? MD_BYTE : (f == FMT_W16) ? MD_PLAIN : MD_RAW;
      default:  m = (f == FMT_W16) ? MD_WR   : MD_WRBAD;
    endcase
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] step_size(input mode_e m);
    logic [ADDR_W-1:0] s;
    unique case (m)
      MD_NIB, MD_BYTE: s = 32'd1;
      MD_WRBAD:        s = 32'd0;
      default:         s = 32'd2;
    endcase
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] loop_addr(input logic [ADDR_W-1:0] n,
                                                  input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W-1:0] l);
    return (n >= l) ? b : n;
  endfunction

  function automatic logic [REG_W-1:0] nib_decode(input logic [3:0] nib,
                                                  input logic [3:0] sh,
                                                  input logic signed [REG_W-1:0] c1,
                                                  input logic signed [REG_W-1:0] c2,
                                                  input logic signed [REG_W-1:0] h1,
                                                  input logic signed [REG_W-1:0] h2);
    logic signed [39:0] pred;
    logic signed [39:0] step;
    logic signed [39:0] val;
    pred = 40'sd1024 + 40'(c1) * 40'(h1) + 40'(c2) * 40'(h2);
    step = 40'(signed'(nib)) <<< sh;
    val  = step + (pred >>> 11);
    if (val > 40'sd32767)       return 16'h7FFF;
    else if (val < -40'sd32767) return 16'h8001;
    else                        return val[REG_W-1:0];
  endfunction
endpackage

// File: rtl/stream_accel_regs.sv
module stream_accel_regs
  import stream_accel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic [REG_W-1:0]      cfg_rdata,
  input  logic                  fin_we,
  input  logic [ADDR_W-1:0]     fin_addr,
  input  logic                  hist_we,
  input  logic [REG_W-1:0]      hist_val,
  input  logic                  hdr_we,
  input  logic [BYTE_W-1:0]     hdr_val,
  input  logic                  err_set,
  output logic [REG_W-1:0]      fmt,
  output logic [ADDR_W-1:0]     cur_addr,
  output logic [ADDR_W-1:0]     beg_addr,
  output logic [ADDR_W-1:0]     lim_addr,
  output logic [BYTE_W-1:0]     pscale,
  output logic [REG_W-1:0]      hist1,
  output logic [REG_W-1:0]      hist2,
  output logic [COEF_N*REG_W-1:0] coef_flat,
  output logic                  err
);
  logic [REG_W-1:0] fmt_q, curh_q, curl_q, begh_q, begl_q, limh_q, liml_q;
  logic [REG_W-1:0] h1_q, h2_q;
  logic [BYTE_W-1:0] psc_q;
  logic err_q;
  logic [REG_W-1:0] coef_q [COEF_N];

  logic sw_wr, sw_low, sw_coef, err_clr;
  assign sw_wr   = cfg_we && !busy;
  assign sw_coef = sw_wr && cfg_addr[CFG_AW-1];
  assign sw_low  = sw_wr && !cfg_addr[CFG_AW-1];
  assign err_clr = sw_low && (cfg_addr == IX_STAT) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '0; curh_q <= '0; curl_q <= '0; begh_q <= '0; begl_q <= '0;
      limh_q <= '0; liml_q <= '0; h1_q <= '0; h2_q <= '0; psc_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (sw_low) begin
        unique case (cfg_addr)
          IX_FMT:   fmt_q  <= cfg_wdata;
          IX_CURH:  curh_q <= cfg_wdata;
          IX_CURL:  curl_q <= cfg_wdata;
          IX_BEGH:  begh_q <= cfg_wdata;
          IX_BEGL:  begl_q <= cfg_wdata;
          IX_LIMH:  limh_q <= cfg_wdata;
          IX_LIML:  liml_q <= cfg_wdata;
          IX_PSC:   psc_q  <= cfg_wdata[BYTE_W-1:0];
          IX_HIST1: h1_q   <= cfg_wdata;
          IX_HIST2: h2_q   <= cfg_wdata;
          default:  ;
        endcase
      end
      if (err_clr) err_q <= 1'b0;
      if (err_set) err_q <= 1'b1;
      if (fin_we) begin
        curh_q <= fin_addr[ADDR_W-1:REG_W];
        curl_q <= fin_addr[REG_W-1:0];
      end
      if (hist_we) begin
        h2_q <= h1_q;
        h1_q <= hist_val;
      end
      if (hdr_we) psc_q <= hdr_val;
    end
  end

  for (genvar i = 0; i < COEF_N; i++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n) coef_q[i] <= '0;
      else if (sw_coef && (cfg_addr[CIDX_W-1:0] == CIDX_W'(i))) coef_q[i] <= cfg_wdata;
    end
    assign coef_flat[i*REG_W +: REG_W] = coef_q[i];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr[CFG_AW-1]) cfg_rdata = coef_q[cfg_addr[CIDX_W-1:0]];
    else begin
      unique case (cfg_addr)
        IX_FMT:   cfg_rdata = fmt_q;
        IX_CURH:  cfg_rdata = curh_q;
        IX_CURL:  cfg_rdata = curl_q;
        IX_BEGH:  cfg_rdata = begh_q;
        IX_BEGL:  cfg_rdata = begl_q;
        IX_LIMH:  cfg_rdata = limh_q;
        IX_LIML:  cfg_rdata = liml_q;
        IX_PSC:   cfg_rdata = {{(REG_W-BYTE_W){1'b0}}, psc_q};
        IX_HIST1: cfg_rdata = h1_q;
        IX_HIST2: cfg_rdata = h2_q;
        IX_STAT:  cfg_rdata = {{(REG_W-1){1'b0}}, err_q};
        default:  cfg_rdata = '0;
      endcase
    end
  end

  assign fmt      = fmt_q;
  assign cur_addr = {curh_q, curl_q};
  assign beg_addr = {begh_q, begl_q};
  assign lim_addr = {limh_q, liml_q};
  assign pscale   = psc_q;
  assign hist1    = h1_q;
  assign hist2    = h2_q;
  assign err      = err_q;

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin_we && !hdr_we |=> $stable(fmt_q) && $stable(curh_q) && $stable(curl_q) && $stable(psc_q)); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q); // R8
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |=> (h2_q == $past(h1_q)) && (h1_q == $past(hist_val))); // R3
endmodule

// File: rtl/stream_accel_nib.sv
module stream_accel_nib
  import stream_accel_pkg::*;
(
  input  logic [BYTE_W-1:0]        pscale,
  input  logic [COEF_N*REG_W-1:0]  coef_flat,
  input  logic [REG_W-1:0]         hist1,
  input  logic [REG_W-1:0]         hist2,
  input  logic [BYTE_W-1:0]        byte_in,
  input  logic                     odd,
  output logic [REG_W-1:0]         sample_out
);
  logic [HDR_SEL_W-1:0] pair;
  logic [3:0] nib;
  logic [REG_W-1:0] c1, c2;

  assign pair = pscale[BYTE_W-1 -: HDR_SEL_W];
  assign nib  = odd ? byte_in[3:0] : byte_in[7:4];
  assign c1   = coef_flat[(2*pair)*REG_W +: REG_W];
  assign c2   = coef_flat[(2*pair+1)*REG_W +: REG_W];
  assign sample_out = nib_decode(nib, pscale[3:0], c1, c2, hist1, hist2);
endmodule

// File: rtl/stream_accel_engine.sv
module stream_accel_engine
  import stream_accel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_main,
  input  logic               rd_alt,
  input  logic               wr_alt,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W-1:0]   fmt,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [ADDR_W-1:0]  beg_addr,
  input  logic [ADDR_W-1:0]  lim_addr,
  input  logic [REG_W-1:0]   dec_sample,
  output logic [BYTE_W-1:0]  dec_byte,
  output logic               dec_odd,
  output logic               busy,
  output logic               done,
  output logic [REG_W-1:0]   sample,
  output logic               mem_valid,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               hdr_we,
  output logic [BYTE_W-1:0]  hdr_val,
  output logic               fin_we,
  output logic [ADDR_W-1:0]  fin_addr,
  output logic               hist_we,
  output logic [REG_W-1:0]   hist_val,
  output logic               err_set
);
  st_e   st;
  op_e   op;
  mode_e mode;
  logic [ADDR_W-1:0] wa;
  logic [BYTE_W-1:0] b0, b1;
  logic [REG_W-1:0]  wdq, smp_q;

  logic xfer, is_read, wrap_hit;
  logic [ADDR_W-1:0] next_raw;
  logic [REG_W-1:0]  result;

  assign xfer     = mem_valid && mem_ready;
  assign is_read  = (op != OP_ALTWR);
  assign next_raw = wa + step_size(mode);
  assign wrap_hit = is_read && (next_raw >= lim_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_MAIN; mode <= MD_PCM;
      wa <= '0; b0 <= '0; b1 <= '0; wdq <= '0; smp_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (rd_main)     begin op <= OP_MAIN;  st <= S_LOAD; end
          else if (rd_alt) begin op <= OP_ALTRD; st <= S_LOAD; end
          else if (wr_alt) begin op <= OP_ALTWR; st <= S_LOAD; wdq <= wr_data; end
        end
        S_LOAD: begin
          mode <= pick_mode(op, fmt);
          wa   <= cur_addr;
          unique case (pick_mode(op, fmt))
            MD_NIB:   st <= (cur_addr[3:0] == 4'd0) ? S_HDR : S_B0;
            MD_WR:    st <= S_WR0;
            MD_WRBAD: st <= S_FIN;
            default:  st <= S_B0;
          endcase
        end
        S_HDR: if (xfer) begin wa <= wa + 32'd2; st <= S_B0; end
        S_B0:  if (xfer) begin
          b0 <= mem_rdata;
          st <= (mode == MD_NIB || mode == MD_BYTE) ? S_FIN : S_B1;
        end
        S_B1:  if (xfer) begin b1 <= mem_rdata; st <= S_FIN; end
        S_WR0: if (xfer) st <= S_WR1;
        S_WR1: if (xfer) st <= S_FIN;
        S_FIN: begin
          if (is_read) smp_q <= result;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = wa;
    mem_wdata = wdq[BYTE_W-1:0];
    unique case (st)
      S_HDR: begin mem_valid = 1'b1; mem_addr = {1'b0, wa[ADDR_W-1:4], 3'b000}; end
      S_B0:  begin
        mem_valid = 1'b1;
        mem_addr  = (mode == MD_NIB) ? {1'b0, wa[ADDR_W-1:1]} : wa;
      end
      S_B1:  begin mem_valid = 1'b1; mem_addr = wa + 32'd1; end
      S_WR0: begin mem_valid = 1'b1; mem_we = 1'b1; mem_wdata = wdq[REG_W-1:BYTE_W]; end
      S_WR1: begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = wa + 32'd1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (mode)
      MD_NIB:  result = dec_sample;
      MD_BYTE: result = {{(REG_W-BYTE_W){1'b0}}, b0};
      default: result = {b0, b1};
    endcase
  end

  assign dec_byte = b0;
  assign dec_odd  = wa[0];
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign sample   = smp_q;
  assign hdr_we   = (st == S_HDR) && xfer;
  assign hdr_val  = mem_rdata;
  assign fin_we   = (st == S_FIN);
  assign fin_addr = is_read ? loop_addr(next_raw, beg_addr, lim_addr) : next_raw;
  assign hist_we  = (st == S_FIN) && (mode == MD_NIB || mode == MD_PCM);
  assign hist_val = result;
  assign err_set  = (st == S_FIN) && (mode == MD_RAW || mode == MD_WRBAD);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done && wrap_hit |=> cur_addr == $past(beg_addr)); // R5
  AST_WRITE_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    done && op == OP_ALTWR && mode == MD_WR |=> cur_addr == $past(wa) + 32'd2); // R7
  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == MD_NIB |-> dec_sample != 16'h8000); // R9
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && is_read) |=> $stable(smp_q)); // R13
endmodule

// File: rtl/stream_accel.sv
module stream_accel
  import stream_accel_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [5:0]   cfg_addr,
  input  logic [15:0]  cfg_wdata,
  output logic [15:0]  cfg_rdata,
  input  logic         rd_main,
  input  logic         rd_alt,
  input  logic         wr_alt,
  input  logic [15:0]  wr_data,
  output logic         busy,
  output logic         done,
  output logic [15:0]  sample,
  output logic         err,
  output logic         mem_valid,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [7:0]   mem_wdata,
  input  logic         mem_ready,
  input  logic [7:0]   mem_rdata
);
  logic [REG_W-1:0]  fmt, hist1, hist2, hist_val, dec_sample;
  logic [ADDR_W-1:0] cur_addr, beg_addr, lim_addr, fin_addr;
  logic [BYTE_W-1:0] pscale, hdr_val, dec_byte;
  logic [COEF_N*REG_W-1:0] coef_flat;
  logic fin_we, hist_we, hdr_we, err_set, dec_odd;

  stream_accel_regs u_regs (
    .clk, .rst_n, .busy, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .fin_we, .fin_addr, .hist_we, .hist_val, .hdr_we, .hdr_val, .err_set,
    .fmt, .cur_addr, .beg_addr, .lim_addr, .pscale, .hist1, .hist2,
    .coef_flat, .err
  );

  stream_accel_nib u_nib (
    .pscale, .coef_flat, .hist1, .hist2,
    .byte_in(dec_byte), .odd(dec_odd), .sample_out(dec_sample)
  );

  stream_accel_engine u_eng (
    .clk, .rst_n, .rd_main, .rd_alt, .wr_alt, .wr_data,
    .fmt, .cur_addr, .beg_addr, .lim_addr, .dec_sample, .dec_byte, .dec_odd,
    .busy, .done, .sample, .mem_valid, .mem_we, .mem_addr, .mem_wdata,
    .mem_ready, .mem_rdata, .hdr_we, .hdr_val, .fin_we, .fin_addr,
    .hist_we, .hist_val, .err_set
  );
endmodule

// File: tb/sim_stream_accel.sv
module sim_stream_accel;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;

  typedef struct packed {
    logic [15:0] fmt;
    logic        alt;
    logic [31:0] cur;
    logic [31:0] beg;
    logic [31:0] lim;
    logic [31:0] nxt;
    logic        bad;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{16'h000A, 1'b0, 32'h0000_0020, 32'h0000_0000, 32'h0000_0080, 32'h0000_0022, 1'b0},
    '{16'h000A, 1'b0, 32'h0000_007E, 32'h0000_0010, 32'h0000_0080, 32'h0000_0010, 1'b0},
    '{16'h000A, 1'b0, 32'h0000_007D, 32'h0000_0010, 32'h0000_0080, 32'h0000_007F, 1'b0},
    '{16'h0005, 1'b1, 32'h0000_0033, 32'h0000_0000, 32'h0000_0040, 32'h0000_0034, 1'b0},
    '{16'h0005, 1'b1, 32'h0000_003F, 32'h0000_0005, 32'h0000_0040, 32'h0000_0005, 1'b0},
    '{16'h000A, 1'b1, 32'h0000_0044, 32'h0000_0000, 32'h0000_0100, 32'h0000_0046, 1'b0},
    '{16'h0007, 1'b0, 32'h0000_0050, 32'h0000_0000, 32'h0000_0100, 32'h0000_0052, 1'b1},
    '{16'h000A, 1'b0, 32'h0001_00F0, 32'h0001_0000, 32'h0001_00F2, 32'h0001_0000, 1'b0},
    '{16'h000A, 1'b0, 32'h0000_0090, 32'h0000_0030, 32'h0000_0020, 32'h0000_0030, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, rd_main = 1'b0, rd_alt = 1'b0, wr_alt = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, wr_data = '0;
  logic [15:0] cfg_rdata, sample;
  logic busy, done, err, mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem_b [256];
  logic stall_on = 1'b0, tick = 1'b0;
  int tests = 0, fails = 0, dones = 0;
  logic [15:0] h1m = '0, h2m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_accel u0 (.*);

  assign mem_rdata = mem_b[mem_addr[7:0]];
  assign mem_ready = stall_on ? tick : 1'b1;
  always @(posedge clk) begin
    tick <= ~tick;
    if (done) dones <= dones + 1;
    if (mem_valid && mem_ready && mem_we) mem_b[mem_addr[7:0]] <= mem_wdata;
  end

  function automatic logic [7:0] bb(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  function automatic logic [15:0] ref_nib(input logic [3:0] nib, input int sh,
                                          input int c1, input int c2, input int h1, input int h2);
    longint n, p, v;
    n = (nib >= 8) ? longint'(nib) - 16 : longint'(nib);
    p = 1024 + longint'(c1) * h1 + longint'(c2) * h2;
    v = n * (longint'(1) << sh) + (p >>> 11);
    if (v > 32767) v = 32767;
    if (v < -32767) v = -32767;
    return 16'(v);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [5:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rcfg(input logic [5:0] a, output logic [15:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic rptr(output logic [31:0] p);
    logic [15:0] hi, lo;
    rcfg(6'd1, hi); rcfg(6'd2, lo);
    p = {hi, lo};
  endtask

  task automatic set_ptrs(input logic [31:0] c, input logic [31:0] b, input logic [31:0] l);
    wcfg(6'd1, c[31:16]); wcfg(6'd2, c[15:0]);
    wcfg(6'd3, b[31:16]); wcfg(6'd4, b[15:0]);
    wcfg(6'd5, l[31:16]); wcfg(6'd6, l[15:0]);
  endtask

  // kind: 0 main read, 1 alt read, 2 alt write
  task automatic access(input int kind);
    rd_main = (kind == 0); rd_alt = (kind == 1); wr_alt = (kind == 2);
    @(negedge clk);
    rd_main = 1'b0; rd_alt = 1'b0; wr_alt = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hang expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] p;
    int d0;
    for (int i = 0; i < 256; i++) mem_b[i] = bb(8'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 10; a++) begin
      rcfg(6'(a), v);
      chk("R1 reg reset", 32'(v), 32'h0);
    end
    rcfg(6'd40, v);
    chk("R1 coef reset", 32'(v), 32'h0);
    chk("R1 idle outputs", {busy, done, err, mem_valid, sample}, 32'h0);

    // vector table: R2 R4 R5 R6 R8 R3
    foreach (VECS[i]) begin
      logic [7:0] c;
      logic [15:0] es;
      wcfg(6'd10, 16'h0001);
      wcfg(6'd0, VECS[i].fmt);
      set_ptrs(VECS[i].cur, VECS[i].beg, VECS[i].lim);
      access(VECS[i].alt ? 1 : 0);
      c = VECS[i].cur[7:0];
      es = (VECS[i].alt && VECS[i].fmt == 16'h0005) ? {8'h00, bb(c)} : {bb(c), bb(8'(c + 8'd1))};
      chk(VECS[i].alt ? "R4 sample" : (VECS[i].bad ? "R8 fallback sample" : "R2 sample"),
          32'(sample), 32'(es));
      rptr(p);
      chk("R5 R6 pointer", p, VECS[i].nxt);
      chk("R8 error flag", 32'(err), 32'(VECS[i].bad));
      if (!VECS[i].alt && !VECS[i].bad) begin h2m = h1m; h1m = es; end
      rcfg(6'd8, v); chk("R3 hist1", 32'(v), 32'(h1m));
      rcfg(6'd9, v); chk("R3 hist2", 32'(v), 32'(h2m));
    end

    // R8 clear
    wcfg(6'd10, 16'h0001);
    chk("R8 clear", 32'(err), 32'h0);

    // R9 ADPCM with header, then without, then clamps
    mem_b[8'h20] = 8'h23; mem_b[8'h21] = 8'h9C; mem_b[8'h22] = 8'h07;
    wcfg(6'd0, 16'h0000);
    wcfg(6'd36, 16'h0800); wcfg(6'd37, 16'hFC00);
    wcfg(6'd8, 16'd100); wcfg(6'd9, 16'd40);
    set_ptrs(32'h40, 32'h0, 32'h1000);
    access(0);
    chk("R9 header decode", 32'(sample), 32'(ref_nib(4'h9, 3, 2048, -1024, 100, 40)));
    rcfg(6'd7, v); chk("R9 header latched", 32'(v), 32'h23);
    rptr(p); chk("R9 pointer", p, 32'h43);
    rcfg(6'd9, v); chk("R3 adpcm hist2", 32'(v), 32'd100);
    access(0);
    chk("R9 odd nibble", 32'(sample), 32'(ref_nib(4'hC, 3, 2048, -1024, 32'(signed'(ref_nib(4'h9, 3, 2048, -1024, 100, 40))), 100)));
    wcfg(6'd7, 16'h000F);
    set_ptrs(32'h45, 32'h0, 32'h1000);
    access(0);
    chk("R9 clamp high", 32'(sample), 32'h7FFF);
    mem_b[8'h22] = 8'h08;
    wcfg(6'd7, 16'h000F);
    set_ptrs(32'h45, 32'h0, 32'h1000);
    access(0);
    chk("R9 clamp low", 32'(sample), 32'h8001);

    // R7 write, no loop check; R13 sample holds
    wcfg(6'd0, 16'h000A);
    set_ptrs(32'h60, 32'h0, 32'h62);
    wr_data = 16'hBEEF;
    v = sample;
    access(2);
    chk("R7 high byte", 32'(mem_b[8'h60]), 32'hBE);
    chk("R7 low byte", 32'(mem_b[8'h61]), 32'hEF);
    rptr(p); chk("R7 pointer no loop", p, 32'h62);
    chk("R13 sample held", 32'(sample), 32'(v));

    // R8 bad write
    wcfg(6'd0, 16'h0005);
    access(2);
    rptr(p); chk("R8 bad write pointer", p, 32'h62);
    chk("R8 bad write memory", 32'(mem_b[8'h62]), 32'(bb(8'h62)));
    chk("R8 bad write flag", 32'(err), 32'h1);
    wcfg(6'd10, 16'h0001);

    // R12 register write in the request cycle is seen by that access
    wcfg(6'd0, 16'h000A);
    set_ptrs(32'h10, 32'h0, 32'h1000);
    cfg_we = 1'b1; cfg_addr = 6'd2; cfg_wdata = 16'h0070; rd_main = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rd_main = 1'b0;
    while (busy) @(negedge clk);
    chk("R12 same-cycle sample", 32'(sample), 32'({bb(8'h70), bb(8'h71)}));
    rptr(p); chk("R12 same-cycle pointer", p, 32'h72);

    // R10 R11 R12 stalls, writes and requests dropped while busy
    stall_on = 1'b1;
    set_ptrs(32'h30, 32'h0, 32'h1000);
    d0 = dones;
    rd_main = 1'b1;
    @(negedge clk);
    rd_main = 1'b0;
    chk("R11 busy after request", 32'(busy), 32'h1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd2; cfg_wdata = 16'h0099; rd_alt = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rd_alt = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 stalled sample", 32'(sample), 32'({bb(8'h30), bb(8'h31)}));
    rptr(p); chk("R12 busy write dropped", p, 32'h32);
    chk("R11 single done", 32'(dones - d0), 32'h1);
    stall_on = 1'b0;

    // R11 priority: main beats alt write
    wcfg(6'd0, 16'h000A);
    set_ptrs(32'h80, 32'h0, 32'h1000);
    wr_data = 16'h1234;
    rd_main = 1'b1; wr_alt = 1'b1;
    @(negedge clk);
    rd_main = 1'b0; wr_alt = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 priority sample", 32'(sample), 32'({bb(8'h80), bb(8'h81)}));
    chk("R11 priority no write", 32'(mem_b[8'h80]), 32'(bb(8'h80)));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule